// File: doc/BRIEF.md
# Multi-Stream Rate Governor Parameter Calculator

This block works out the pacing parameters of one stream on a multi-stream transport link: how many symbols per time slot the stream may emit. Software or a sequencer places the stream's pixel clock, link rate, lane count, bits per pixel, bandwidth number and optional overhead factors on the inputs and pulses `start`. The block computes the result over a few hundred cycles and then presents an integer symbol count, a fraction scaled by 256, and the raw target slot count in 32.32 fixed point. The outputs are marked valid by a one-cycle `done` pulse.

All arithmetic is unsigned 32.32 fixed point. There are three divisions in each job, and they all go through one shared restoring divider that produces one quotient bit per cycle. The multiplications are single-cycle steps, each in its own state of the controller. If the link rate or the lane count is zero, the job cannot start. In that case the block raises a one-cycle error pulse and leaves the outputs untouched.

Top module: `mst_rg_calc`

## Requirements
- R1: A `start` pulse seen while idle captures every operand input. Later changes to those inputs do not alter the job's result.
- R2: The low slot bound is floor(pclk·bpp·64·2^32 / (lrate·lanes·8)), taken as a 32.32 value.
- R3: The high slot bound is floor(bwnum·54000·2^32 / (lrate·lanes)), taken as a 32.32 value.
- R4: `raw_target` is floor((low + high)/2), after any overhead scaling, and is presented in 32.32 form (bits 63:32 integer).
- R5: When `comp_en` is 1, `comp_bpp` is used in place of `bpp` in the low bound.
- R6: A nonzero `comp_ovh` multiplies the averaged value first, and a nonzero `fec_ovh` multiplies it next. Each product is floor(a·b/2^32). A zero factor is skipped.
- R7: Quantization: ts_int = integer part of the raw target. If the raw target has a nonzero fraction, ts_num = floor(fraction·256·lanes). If the fraction is zero, ts_num = 256·lanes.
- R8: `x_int` is the integer part of (ts_int + ts_num/(256·lanes))·lanes. The quotient is taken as a 32.32 value.
- R9: `y_frac` is the fractional part of that product times 256, rounded up when not exact. Its range is 0 to 256.
- R10: After reset, `done`, `err`, `busy` and the outputs are 0. `done` lasts exactly one cycle, and the outputs hold their values until the next completed job.
- R11: A `start` with `lrate` or `lanes` equal to 0 gives a one-cycle `err`, no `done`, and unchanged outputs.
- R12: A `start` pulse while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job; operands are captured |
| pclk_khz | input | 20 | Pixel clock in kHz |
| link_rate | input | 20 | Per-lane link rate, in the same unit as the pixel clock |
| lane_cnt | input | 3 | Number of active lanes |
| bpp | input | 6 | Uncompressed bits per pixel |
| comp_en | input | 1 | Use the compressed bits per pixel |
| comp_bpp | input | 6 | Compressed bits per pixel |
| bw_num | input | 16 | Stream bandwidth number |
| comp_ovh | input | 64 | Compression overhead factor, 32.32; 0 means none |
| fec_ovh | input | 64 | Error-correction overhead factor, 32.32; 0 means none |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle result-valid pulse |
| err | output | 1 | One-cycle pulse on a zero divisor |
| x_int | output | 32 | Integer symbols per slot |
| y_frac | output | 9 | Fraction of a symbol, in 1/256 steps, rounded up |
| raw_target | output | 64 | Raw target slot count, 32.32 |

## Verification
The bench sweeps lane counts 1 to 4 against several pixel clocks, pixel depths and bandwidth numbers, and compares every output against arithmetic done independently in the bench.

Targeted cases cover the following corner cases:
- **Exactly integral raw target.** This is the case where ts_num jumps to 256·lanes. A design that kept the fraction at zero would report one lane-multiple too few symbols.
- **Zero bandwidth number and zero pixel clock.** These isolate each bound. A swapped scale or a missing ×8 would show up directly in `raw_target`.
- **Overhead factors, including a zero one.** These catch a factor that is applied when it should be skipped, or applied in the wrong place.
- **Compressed bit depth.** This catches a design that ignores `comp_en`.
- **Operand changes and repeated starts during a job.** A design that does not capture its operands, or that restarts, would return a different result.
- **Zero lanes and zero rate.** A design that divides anyway would assert `done` or corrupt the held outputs.

// File: rtl/rg_pkg.sv
package rg_pkg;

    localparam int FX_W      = 64;
    localparam int FX_FRAC   = 32;
    localparam int HI_SCALE  = 54000;
    localparam int LO_NUM_SH = 6;
    localparam int LO_DEN_SH = 3;
    localparam int SUB_SH    = 8;

    typedef struct packed {
        logic [FX_W-FX_FRAC-1:0] ip;
        logic [FX_FRAC-1:0]      fp;
    } fx_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LO_GO,
        S_LO_WAIT,
        S_HI_GO,
        S_HI_WAIT,
        S_AVG,
        S_OVH_C,
        S_OVH_F,
        S_QF_GO,
        S_QF_WAIT,
        S_FIN
    } rg_state_e;

    // 32.32 product, truncated to 32.32
    function automatic fx_t fx_mul(input fx_t a, input fx_t b);
        logic [2*FX_W-1:0] p;
        p = {{FX_W{1'b0}}, a} * {{FX_W{1'b0}}, b};
        return fx_t'(p[FX_W+FX_FRAC-1:FX_FRAC]);
    endfunction

    function automatic fx_t fx_half_sum(input fx_t a, input fx_t b);
        logic [FX_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return fx_t'(s[FX_W:1]);
    endfunction

endpackage

// File: rtl/rg_divider.sv
// Restoring divider: quotient = floor(num * 2^32 / den), one bit per cycle.
module rg_divider #(
    parameter int N_W = 32,
    parameter int D_W = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [N_W-1:0]    num,
    input  logic [D_W-1:0]    den,
    output logic              fin,
    output logic [N_W+31:0]   quo
);
    import rg_pkg::*;

    localparam int Q_W   = N_W + FX_FRAC;
    localparam int CNT_W = $clog2(Q_W + 1);

    logic [Q_W-1:0]   shreg;
    logic [D_W-1:0]   rem;
    logic [D_W-1:0]   den_q;
    logic [CNT_W-1:0] cnt;
    logic             run;
    logic [D_W:0]     trial;
    logic             fits;

    always_comb begin
        trial = {rem, shreg[Q_W-1]};
        fits  = (trial >= {1'b0, den_q});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            rem   <= '0;
            den_q <= '0;
            cnt   <= '0;
            run   <= 1'b0;
            fin   <= 1'b0;
            quo   <= '0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                shreg <= {num, {FX_FRAC{1'b0}}};
                rem   <= '0;
                den_q <= den;
                quo   <= '0;
                cnt   <= CNT_W'(Q_W);
                run   <= 1'b1;
            end else if (run) begin
                shreg <= {shreg[Q_W-2:0], 1'b0};
                if (fits) begin
                    rem <= D_W'(trial - {1'b0, den_q});
                    quo <= {quo[Q_W-2:0], 1'b1};
                end else begin
                    rem <= trial[D_W-1:0];
                    quo <= {quo[Q_W-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CNT_W'(1)) begin
                    run <= 1'b0;
                    fin <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rg_operands.sv
// Dividend and divisor for the two slot bounds.
module rg_operands #(
    parameter int PCLK_W = 20,
    parameter int LRATE_W = 20,
    parameter int LANE_W = 3,
    parameter int BPP_W  = 6,
    parameter int BW_W   = 16,
    parameter int NUM_W  = 32,
    parameter int DEN_W  = 26
) (
    input  logic [PCLK_W-1:0]  pclk,
    input  logic [LRATE_W-1:0] lrate,
    input  logic [LANE_W-1:0]  lanes,
    input  logic [BPP_W-1:0]   bpp,
    input  logic               comp_en,
    input  logic [BPP_W-1:0]   comp_bpp,
    input  logic [BW_W-1:0]    bwnum,
    output logic [NUM_W-1:0]   lo_num,
    output logic [DEN_W-1:0]   lo_den,
    output logic [NUM_W-1:0]   hi_num,
    output logic [DEN_W-1:0]   hi_den
);
    import rg_pkg::*;

    logic [BPP_W-1:0] bpp_eff;
    logic [DEN_W-1:0] rate_lanes;

    always_comb begin
        bpp_eff    = comp_en ? comp_bpp : bpp;
        rate_lanes = DEN_W'(lrate) * DEN_W'(lanes);
        lo_num     = (NUM_W'(pclk) * NUM_W'(bpp_eff)) << LO_NUM_SH;
        lo_den     = rate_lanes << LO_DEN_SH;
        hi_num     = NUM_W'(bwnum) * NUM_W'(HI_SCALE);
        hi_den     = rate_lanes;
    end
endmodule

// File: rtl/rg_quant.sv
// Split the raw target into integer part and sub-slot numerator.
module rg_quant #(
    parameter int LANE_W = 3,
    parameter int TSN_W  = 12
) (
    input  rg_pkg::fx_t        raw,
    input  logic [LANE_W-1:0]  lanes,
    output logic [31:0]        ts_int,
    output logic [TSN_W-1:0]   ts_num
);
    import rg_pkg::*;

    localparam int P_W = FX_FRAC + SUB_SH + LANE_W;

    logic [P_W-1:0] prod;
    logic [TSN_W-1:0] full;

    always_comb begin
        prod   = P_W'(raw.fp) * P_W'({lanes, {SUB_SH{1'b0}}});
        full   = TSN_W'({lanes, {SUB_SH{1'b0}}});
        ts_int = raw.ip;
        ts_num = (raw.fp != '0) ? TSN_W'(prod >> FX_FRAC) : full;
    end
endmodule

// File: rtl/rg_target.sv
// Final symbols-per-slot from the quantized target.
module rg_target #(
    parameter int LANE_W = 3
) (
    input  logic [31:0]        ts_int,
    input  rg_pkg::fx_t        ts_frac,
    input  logic [LANE_W-1:0]  lanes,
    output logic [31:0]        x_int,
    output logic [8:0]         y_frac
);
    import rg_pkg::*;

    logic [FX_W-1:0] base;
    logic [FX_W-1:0] tgt;

    always_comb begin
        base   = {ts_int, {FX_FRAC{1'b0}}} + ts_frac;
        tgt    = base * FX_W'(lanes);
        x_int  = tgt[FX_W-1:FX_FRAC];
        y_frac = {1'b0, tgt[FX_FRAC-1:FX_FRAC-SUB_SH]}
               + 9'(|tgt[FX_FRAC-SUB_SH-1:0]);
    end
endmodule

// File: rtl/mst_rg_calc.sv
module mst_rg_calc #(
    parameter int PCLK_W  = 20,
    parameter int LRATE_W = 20,
    parameter int LANE_W  = 3,
    parameter int BPP_W   = 6,
    parameter int BW_W    = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [PCLK_W-1:0]  pclk_khz,
    input  logic [LRATE_W-1:0] link_rate,
    input  logic [LANE_W-1:0]  lane_cnt,
    input  logic [BPP_W-1:0]   bpp,
    input  logic               comp_en,
    input  logic [BPP_W-1:0]   comp_bpp,
    input  logic [BW_W-1:0]    bw_num,
    input  logic [63:0]        comp_ovh,
    input  logic [63:0]        fec_ovh,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [31:0]        x_int,
    output logic [8:0]         y_frac,
    output logic [63:0]        raw_target
);
    import rg_pkg::*;

    localparam int LO_NW = PCLK_W + BPP_W + LO_NUM_SH;
    localparam int HI_NW = BW_W + 16;
    localparam int NUM_W = (LO_NW > HI_NW) ? LO_NW : HI_NW;
    localparam int DEN_W = LRATE_W + LANE_W + LO_DEN_SH;
    localparam int TSN_W = LANE_W + SUB_SH + 1;

    rg_state_e st;

    logic [PCLK_W-1:0]  pclk_q;
    logic [LRATE_W-1:0] lrate_q;
    logic [LANE_W-1:0]  lanes_q;
    logic [BPP_W-1:0]   bpp_q;
    logic               cen_q;
    logic [BPP_W-1:0]   cbpp_q;
    logic [BW_W-1:0]    bw_q;
    fx_t                covh_q;
    fx_t                fovh_q;

    fx_t         lo_q;
    fx_t         hi_q;
    fx_t         raw_q;
    fx_t         qfrac_q;
    logic [31:0] ts_int_q;

    logic [NUM_W-1:0] lo_num, hi_num;
    logic [DEN_W-1:0] lo_den, hi_den;

    logic [31:0]      q_int;
    logic [TSN_W-1:0] q_num;

    logic             div_go;
    logic [NUM_W-1:0] div_num;
    logic [DEN_W-1:0] div_den;
    logic             div_fin;
    logic [NUM_W+31:0] div_quo;
    fx_t              div_fx;

    logic [31:0] t_x;
    logic [8:0]  t_y;

    rg_operands #(
        .PCLK_W(PCLK_W), .LRATE_W(LRATE_W), .LANE_W(LANE_W),
        .BPP_W(BPP_W), .BW_W(BW_W), .NUM_W(NUM_W), .DEN_W(DEN_W)
    ) u_ops (
        .pclk(pclk_q), .lrate(lrate_q), .lanes(lanes_q), .bpp(bpp_q),
        .comp_en(cen_q), .comp_bpp(cbpp_q), .bwnum(bw_q),
        .lo_num(lo_num), .lo_den(lo_den), .hi_num(hi_num), .hi_den(hi_den)
    );

    rg_quant #(.LANE_W(LANE_W), .TSN_W(TSN_W)) u_quant (
        .raw(raw_q), .lanes(lanes_q), .ts_int(q_int), .ts_num(q_num)
    );

    rg_target #(.LANE_W(LANE_W)) u_tgt (
        .ts_int(ts_int_q), .ts_frac(qfrac_q), .lanes(lanes_q),
        .x_int(t_x), .y_frac(t_y)
    );

    // Shared divider operand selection
    always_comb begin
        div_go  = 1'b0;
        div_num = lo_num;
        div_den = lo_den;
        unique case (st)
            S_LO_GO: div_go = 1'b1;
            S_HI_GO: begin
                div_go  = 1'b1;
                div_num = hi_num;
                div_den = hi_den;
            end
            S_QF_GO, S_QF_WAIT: begin
                div_go  = (st == S_QF_GO);
                div_num = NUM_W'(q_num);
                div_den = DEN_W'({lanes_q, {SUB_SH{1'b0}}});
            end
            S_HI_WAIT: begin
                div_num = hi_num;
                div_den = hi_den;
            end
            default: ;
        endcase
    end

    rg_divider #(.N_W(NUM_W), .D_W(DEN_W)) u_div (
        .clk(clk), .rst(rst), .go(div_go), .num(div_num), .den(div_den),
        .fin(div_fin), .quo(div_quo)
    );

    assign div_fx = fx_t'(div_quo[FX_W-1:0]);
    assign busy   = (st != S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_IDLE;
            pclk_q     <= '0;
            lrate_q    <= '0;
            lanes_q    <= '0;
            bpp_q      <= '0;
            cen_q      <= 1'b0;
            cbpp_q     <= '0;
            bw_q       <= '0;
            covh_q     <= '0;
            fovh_q     <= '0;
            lo_q       <= '0;
            hi_q       <= '0;
            raw_q      <= '0;
            qfrac_q    <= '0;
            ts_int_q   <= '0;
            done       <= 1'b0;
            err        <= 1'b0;
            x_int      <= '0;
            y_frac     <= '0;
            raw_target <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (st)
                S_IDLE: if (start) begin
                    pclk_q  <= pclk_khz;
                    lrate_q <= link_rate;
                    lanes_q <= lane_cnt;
                    bpp_q   <= bpp;
                    cen_q   <= comp_en;
                    cbpp_q  <= comp_bpp;
                    bw_q    <= bw_num;
                    covh_q  <= fx_t'(comp_ovh);
                    fovh_q  <= fx_t'(fec_ovh);
                    if (link_rate == '0 || lane_cnt == '0)
                        err <= 1'b1;
                    else
                        st <= S_LO_GO;
                end
                S_LO_GO:   st <= S_LO_WAIT;
                S_LO_WAIT: if (div_fin) begin
                    lo_q <= div_fx;
                    st   <= S_HI_GO;
                end
                S_HI_GO:   st <= S_HI_WAIT;
                S_HI_WAIT: if (div_fin) begin
                    hi_q <= div_fx;
                    st   <= S_AVG;
                end
                S_AVG: begin
                    raw_q <= fx_half_sum(lo_q, hi_q);
                    st    <= S_OVH_C;
                end
                S_OVH_C: begin
                    if (covh_q != '0) raw_q <= fx_mul(raw_q, covh_q);
                    st <= S_OVH_F;
                end
                S_OVH_F: begin
                    if (fovh_q != '0) raw_q <= fx_mul(raw_q, fovh_q);
                    st <= S_QF_GO;
                end
                S_QF_GO: begin
                    ts_int_q <= q_int;
                    st       <= S_QF_WAIT;
                end
                S_QF_WAIT: if (div_fin) begin
                    qfrac_q <= div_fx;
                    st      <= S_FIN;
                end
                S_FIN: begin
                    x_int      <= t_x;
                    y_frac     <= t_y;
                    raw_target <= raw_q;
                    done       <= 1'b1;
                    st         <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rg_calc_checker.sv
module rg_calc_checker #(
    parameter int LRATE_W = 20,
    parameter int LANE_W  = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic               err,
    input logic [LRATE_W-1:0] link_rate,
    input logic [LANE_W-1:0]  lane_cnt,
    input logic [31:0]        x_int,
    input logic [8:0]         y_frac,
    input logic [63:0]        raw_target
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(x_int) && $stable(y_frac) && $stable(raw_target))); // R10

    AST_ZERO_DIV_ERR: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (link_rate == '0 || lane_cnt == '0)) |=> (err && !busy)); // R11

    AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (rst)
        err |-> !done); // R11

    AST_FRAC_RANGE: assert property (@(posedge clk) disable iff (rst)
        done |-> (y_frac <= 9'd256)); // R9

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy)); // R12
endmodule

bind mst_rg_calc rg_calc_checker #(.LRATE_W(LRATE_W), .LANE_W(LANE_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .err(err),
    .link_rate(link_rate), .lane_cnt(lane_cnt), .x_int(x_int),
    .y_frac(y_frac), .raw_target(raw_target)
);

// File: tb/tb_mst_rg_calc.sv
`timescale 1ns/1ps
module tb_mst_rg_calc;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [19:0] pclk_khz;
    logic [19:0] link_rate;
    logic [2:0]  lane_cnt;
    logic [5:0]  bpp;
    logic        comp_en;
    logic [5:0]  comp_bpp;
    logic [15:0] bw_num;
    logic [63:0] comp_ovh;
    logic [63:0] fec_ovh;
    logic        busy, done, err;
    logic [31:0] x_int;
    logic [8:0]  y_frac;
    logic [63:0] raw_target;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    mst_rg_calc dut (
        .clk(clk), .rst(rst), .start(start), .pclk_khz(pclk_khz),
        .link_rate(link_rate), .lane_cnt(lane_cnt), .bpp(bpp),
        .comp_en(comp_en), .comp_bpp(comp_bpp), .bw_num(bw_num),
        .comp_ovh(comp_ovh), .fec_ovh(fec_ovh), .busy(busy), .done(done),
        .err(err), .x_int(x_int), .y_frac(y_frac), .raw_target(raw_target)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Expected values from the stated arithmetic
    task automatic model(input int unsigned pc, input int unsigned lr, input int unsigned ln,
                         input int unsigned bp, input bit cen, input int unsigned cbp,
                         input int unsigned pb, input logic [63:0] co, input logic [63:0] fo,
                         output logic [63:0] e_raw, output logic [31:0] e_x, output logic [8:0] e_y);
        logic [127:0] n, d, lo, hi, r, tn, tf, tg;
        int unsigned b;
        b  = cen ? cbp : bp;
        n  = 128'(pc) * 128'(b) * 128'd64;
        d  = 128'(lr) * 128'(ln) * 128'd8;
        lo = ((n << 32) / d) & 128'hFFFF_FFFF_FFFF_FFFF;
        n  = 128'(pb) * 128'd54000;
        d  = 128'(lr) * 128'(ln);
        hi = ((n << 32) / d) & 128'hFFFF_FFFF_FFFF_FFFF;
        r  = (lo + hi) >> 1;
        if (co != 0) r = ((r * 128'(co)) >> 32) & 128'hFFFF_FFFF_FFFF_FFFF;
        if (fo != 0) r = ((r * 128'(fo)) >> 32) & 128'hFFFF_FFFF_FFFF_FFFF;
        e_raw = r[63:0];
        if (r[31:0] != 0) tn = (128'(r[31:0]) * 128'(256 * ln)) >> 32;
        else              tn = 128'(256 * ln);
        tf = (tn << 32) / 128'(256 * ln);
        tg = ((({96'd0, r[63:32]} << 32) + tf) & 128'hFFFF_FFFF_FFFF_FFFF) * 128'(ln);
        e_x = tg[63:32];
        e_y = {1'b0, tg[31:24]} + 9'(tg[23:0] != 0);
    endtask

    task automatic run_case(input string tag, input int unsigned pc, input int unsigned lr,
                            input int unsigned ln, input int unsigned bp, input bit cen,
                            input int unsigned cbp, input int unsigned pb,
                            input logic [63:0] co, input logic [63:0] fo, input bit disturb);
        logic [63:0] e_raw;
        logic [31:0] e_x, hold_x;
        logic [8:0]  e_y;
        bit got, bad_err;
        model(pc, lr, ln, bp, cen, cbp, pb, co, fo, e_raw, e_x, e_y);
        @(negedge clk);
        pclk_khz = 20'(pc); link_rate = 20'(lr); lane_cnt = 3'(ln); bpp = 6'(bp);
        comp_en = cen; comp_bpp = 6'(cbp); bw_num = 16'(pb); comp_ovh = co; fec_ovh = fo;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            // R1 / R12: operands change and start repeats mid-job
            @(negedge clk);
            pclk_khz = 20'd777; bw_num = 16'd3; lane_cnt = 3'd0; bpp = 6'd1;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        got = 0; bad_err = 0;
        for (int i = 0; i < 3000; i++) begin
            if (done) begin got = 1; break; end
            if (err) bad_err = 1;
            @(negedge clk);
        end
        check({tag, " R10 done seen"}, 64'(got), 64'd1);
        check({tag, " R11 no err"}, 64'(bad_err), 64'd0);
        check({tag, " R4 raw_target"}, raw_target, e_raw);
        check({tag, " R8 x_int"}, 64'(x_int), 64'(e_x));
        check({tag, " R9 y_frac"}, 64'(y_frac), 64'(e_y));
        hold_x = x_int;
        @(negedge clk);
        check({tag, " R10 done one cycle"}, 64'(done), 64'd0);
        check({tag, " R10 hold"}, 64'(x_int), 64'(hold_x));
        if (disturb) begin
            lane_cnt = 3'(ln);
        end
    endtask

    task automatic err_case(input string tag, input int unsigned lr, input int unsigned ln);
        logic [31:0] hx;
        logic [63:0] hr;
        bit saw_err, saw_done;
        hx = x_int; hr = raw_target;
        @(negedge clk);
        link_rate = 20'(lr); lane_cnt = 3'(ln); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        saw_err = 0; saw_done = 0;
        for (int i = 0; i < 20; i++) begin
            if (err) saw_err = 1;
            if (done) saw_done = 1;
            @(negedge clk);
        end
        check({tag, " R11 err"}, 64'(saw_err), 64'd1);
        check({tag, " R11 no done"}, 64'(saw_done), 64'd0);
        check({tag, " R11 x held"}, 64'(x_int), 64'(hx));
        check({tag, " R11 raw held"}, raw_target, hr);
    endtask

    initial begin
        int unsigned pcs[3];
        int unsigned bps[2];
        int unsigned pbs[3];
        pcs[0] = 148500; pcs[1] = 25175; pcs[2] = 594000;
        bps[0] = 24; bps[1] = 30;
        pbs[0] = 600; pbs[1] = 1; pbs[2] = 2400;
        rst = 1'b1; start = 1'b0; pclk_khz = '0; link_rate = '0; lane_cnt = '0;
        bpp = '0; comp_en = 1'b0; comp_bpp = '0; bw_num = '0; comp_ovh = '0; fec_ovh = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 reset done", 64'(done), 64'd0);
        check("R10 reset busy", 64'(busy), 64'd0);
        check("R10 reset x_int", 64'(x_int), 64'd0);
        check("R10 reset raw", raw_target, 64'd0);

        // Sweep R2 R3 R4 R7 R8 R9
        for (int ln = 1; ln <= 4; ln++)
            for (int a = 0; a < 3; a++)
                for (int b = 0; b < 2; b++)
                    for (int c = 0; c < 3; c++)
                        run_case("sweep", pcs[a], 270000, ln, bps[b], 1'b0, 0, pbs[c],
                                 64'd0, 64'd0, 1'b0);

        run_case("R2 low bound only", 148500, 540000, 2, 24, 1'b0, 0, 0, 64'd0, 64'd0, 1'b0);
        run_case("R3 high bound only", 0, 162000, 4, 24, 1'b0, 0, 1234, 64'd0, 64'd0, 1'b0);
        // R7: raw exactly 2.0 -> ts_num = 256*lanes, x = 3, y = 0
        run_case("R7 integral", 3375, 27000, 1, 2, 1'b0, 0, 1, 64'd0, 64'd0, 1'b0);
        check("R7 integral x=3", 64'(x_int), 64'd3);
        check("R7 integral y=0", 64'(y_frac), 64'd0);
        run_case("R5 compressed bpp", 297000, 270000, 4, 30, 1'b1, 8, 900, 64'd0, 64'd0, 1'b0);
        run_case("R6 comp ovh", 148500, 270000, 4, 24, 1'b0, 0, 600,
                 64'h0000_0001_0800_0000, 64'd0, 1'b0);
        run_case("R6 fec ovh", 148500, 270000, 4, 24, 1'b0, 0, 600,
                 64'd0, 64'h0000_0001_0300_0000, 1'b0);
        run_case("R6 both ovh", 594000, 810000, 3, 24, 1'b0, 0, 2000,
                 64'h0000_0001_0800_0000, 64'h0000_0001_0300_0000, 1'b0);
        run_case("R1 R12 disturbed", 241500, 540000, 4, 24, 1'b0, 0, 1500,
                 64'd0, 64'd0, 1'b1);
        err_case("R11 zero lanes", 270000, 0);
        err_case("R11 zero rate", 0, 4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule